// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This unit is the timer that sits beside a processor core. It holds a 32-bit counter that steps up by one on each enabled tick and a 32-bit comparison value. When the counter steps onto the comparison value, the unit raises a timer interrupt. The interrupt stays raised until software writes a new comparison value. A three-bit routing field picks which of eight interrupt lines carries the request.

Software reaches both registers through one write port. A select bit on that port chooses between the counter and the comparison value. A freeze input stops the counter and blocks any match. A revision input decides whether a match also sets a pending flag, which a cause register can show. The tick source and the interrupt controller lie outside this block.

Top module: `tmr_cc_top`

## Requirements
- R1: After reset, `count_val` and `compare_val` read zero, all eight `irq_lines` are low, and `pend_flag` is low.
- R2: In a cycle where `tick_en` is 1, `count_freeze` is 0 and no counter write occurs, `count_val` rises by one at the clock edge. When `tick_en` is 0, `count_val` keeps its value.
- R3: The counter steps from 32'hFFFF_FFFF to 32'h0000_0000.
- R4: While `count_freeze` is 1, `count_val` holds its value and no match is signalled.
- R5: A write with `wr_sel` = 0 loads `wr_data` into the counter at the next edge. It overrides a tick in the same cycle, and it never raises the interrupt, even when the loaded value equals the comparison value.
- R6: A write with `wr_sel` = 1 loads `wr_data` into the comparison value at the next edge.
- R7: When an enabled step makes the counter equal to the comparison value, the interrupt is raised at that same clock edge.
- R8: A match sets `pend_flag` only when `rev2_mode` is 1 in the matching cycle.
- R9: A comparison write clears both the interrupt and `pend_flag`. It wins over a match in the same cycle.
- R10: While the interrupt is raised, exactly one line is high, `irq_lines[route_sel]`. Otherwise all lines are low.
- R11: When `route_sel` changes while the interrupt is raised, the request moves at once to the newly selected line.
- R12: Once raised, the interrupt stays high across further ticks until a comparison write or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable tick from the prescaler |
| count_freeze | input | 1 | Stops counting and match detection when 1 |
| rev2_mode | input | 1 | Enables the pending flag when 1 |
| route_sel | input | 3 | Index of the interrupt line to drive |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the counter, 1 selects the comparison value |
| wr_data | input | 32 | Write data |
| count_val | output | 32 | Current counter value |
| compare_val | output | 32 | Current comparison value |
| irq_lines | output | 8 | Timer interrupt, one-hot on the routed line |
| pend_flag | output | 1 | Timer pending flag for a cause register |

## Verification
The assertions assume that the inputs are stable around the sampling edge and that a write strobe carries a single, defined select bit. They also assume `route_sel` is always a legal index. The three-bit field makes every value legal, so this holds by width. The stimulus changes inputs only on the falling clock edge and uses one write per cycle. It places ticks, freezes and comparison writes on the exact cycles around each match, so every priority case is reached while the inputs stay within those assumptions.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int unsigned TMR_W = 32;

    typedef enum logic {
        SEL_COUNT   = 1'b0,
        SEL_COMPARE = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic [TMR_W-1:0] count;
    } cnt_state_t;

    typedef struct packed {
        logic [TMR_W-1:0] compare;
        logic             active;
        logic             pend;
    } match_state_t;

endpackage

// File: rtl/tmr_count_reg.sv
module tmr_count_reg
    import tmr_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ld,
    input  logic [TMR_W-1:0] ld_val,
    output logic [TMR_W-1:0] count_q,
    output logic [TMR_W-1:0] count_inc,
    output logic             step
);

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        count_inc = st_q.count + TMR_W'(1);
        step      = adv && !ld;
        if (ld) begin
            st_d.count = ld_val;
        end else if (adv) begin
            st_d.count = count_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;

endmodule

// File: rtl/tmr_match_ctl.sv
module tmr_match_ctl
    import tmr_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [TMR_W-1:0] count_inc,
    input  logic             cmp_wr,
    input  logic [TMR_W-1:0] cmp_wr_val,
    input  logic             rev2,
    output logic [TMR_W-1:0] compare_q,
    output logic             active_q,
    output logic             pend_q
);

    match_state_t st_d, st_q;
    logic         hit;

    always_comb begin
        st_d = st_q;
        hit  = step && (count_inc == st_q.compare);
        if (cmp_wr) begin
            st_d.compare = cmp_wr_val;
            st_d.active  = 1'b0;
            st_d.pend    = 1'b0;
        end else if (hit) begin
            st_d.active = 1'b1;
            if (rev2) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign compare_q = st_q.compare;
    assign active_q  = st_q.active;
    assign pend_q    = st_q.pend;

endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
    parameter int unsigned LINES = 8,
    localparam int unsigned SEL_W = $clog2(LINES)
) (
    input  logic             active,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] lines
);

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        assign lines[gi] = active && (sel == SEL_W'(gi));
    end

endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
    import tmr_cc_pkg::*;
#(
    parameter int unsigned IRQ_LINES = 8,
    localparam int unsigned RT_W = $clog2(IRQ_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 count_freeze,
    input  logic                 rev2_mode,
    input  logic [RT_W-1:0]      route_sel,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [TMR_W-1:0]     wr_data,
    output logic [TMR_W-1:0]     count_val,
    output logic [TMR_W-1:0]     compare_val,
    output logic [IRQ_LINES-1:0] irq_lines,
    output logic                 pend_flag
);

    logic             cnt_ld, cmp_ld, adv, step, active;
    logic [TMR_W-1:0] count_inc;

    always_comb begin
        cnt_ld = wr_en && (wr_target_e'(wr_sel) == SEL_COUNT);
        cmp_ld = wr_en && (wr_target_e'(wr_sel) == SEL_COMPARE);
        adv    = tick_en && !count_freeze;
    end

    tmr_count_reg u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .ld        (cnt_ld),
        .ld_val    (wr_data),
        .count_q   (count_val),
        .count_inc (count_inc),
        .step      (step)
    );

    tmr_match_ctl u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .count_inc  (count_inc),
        .cmp_wr     (cmp_ld),
        .cmp_wr_val (wr_data),
        .rev2       (rev2_mode),
        .compare_q  (compare_val),
        .active_q   (active),
        .pend_q     (pend_flag)
    );

    tmr_irq_route #(.LINES(IRQ_LINES)) u_route (
        .active (active),
        .sel    (route_sel),
        .lines  (irq_lines)
    );

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        count_freeze,
    input logic        rev2_mode,
    input logic [2:0]  route_sel,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] count_val,
    input logic [31:0] compare_val,
    input logic [7:0]  irq_lines,
    input logic        pend_flag
);

    logic cw, kw, go;
    assign cw = wr_en && !wr_sel;
    assign kw = wr_en && wr_sel;
    assign go = tick_en && !count_freeze && !cw;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> count_val == $past(count_val) + 32'd1);                        // R2
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count_freeze && !cw) |=> $stable(count_val));                        // R4
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> count_val == $past(wr_data));                                  // R5
    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kw |=> compare_val == $past(wr_data));                                // R6
    AST_MATCH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !kw && (count_val + 32'd1 == compare_val)) |=> irq_lines != 8'd0); // R7
    AST_PEND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_flag) |-> $past(rev2_mode));                               // R8
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        kw |=> (irq_lines == 8'd0) && !pend_flag);                            // R9
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));                                                 // R10
    AST_ROUTE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines != 8'd0) |-> irq_lines[route_sel]);                        // R11
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_lines != 8'd0) && !kw) |=> irq_lines != 8'd0);                  // R12

endmodule

bind tmr_cc_top tmr_cc_chk u_chk (.*);

// File: tb/tb_tmr_cc_top.sv
module tb_tmr_cc_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic        sel;
        logic [31:0] data;
        logic        tick;
        logic        frz;
        logic        rev2;
        logic [2:0]  route;
        logic [31:0] ecnt;
        logic [7:0]  eirq;
        logic        epend;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'd5,  1'b0, 1'b0, 1'b0, 3'd0, 32'd0, 8'h00, 1'b0}, // R6
        '{1'b1, 1'b0, 32'd3,  1'b1, 1'b0, 1'b0, 3'd0, 32'd3, 8'h00, 1'b0}, // R5 write beats tick
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b0, 1'b1, 3'd2, 32'd4, 8'h00, 1'b0}, // R2
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b0, 1'b1, 3'd2, 32'd5, 8'h04, 1'b1}, // R7 R8
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b0, 1'b1, 3'd2, 32'd6, 8'h04, 1'b1}, // R12
        '{1'b0, 1'b0, 32'd0,  1'b0, 1'b0, 1'b1, 3'd5, 32'd6, 8'h20, 1'b1}, // R11
        '{1'b1, 1'b1, 32'd8,  1'b1, 1'b0, 1'b1, 3'd5, 32'd7, 8'h00, 1'b0}, // R9
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b1, 1'b0, 3'd7, 32'd7, 8'h00, 1'b0}, // R4
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b1, 1'b0, 3'd7, 32'd7, 8'h00, 1'b0}, // R4
        '{1'b0, 1'b0, 32'd0,  1'b1, 1'b0, 1'b0, 3'd7, 32'd8, 8'h80, 1'b0}, // R8 R10
        '{1'b1, 1'b1, 32'h10, 1'b0, 1'b0, 1'b0, 3'd7, 32'd8, 8'h00, 1'b0}, // R9
        '{1'b0, 1'b0, 32'd0,  1'b0, 1'b0, 1'b0, 3'd7, 32'd8, 8'h00, 1'b0}  // R2 hold
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, count_freeze = 1'b0, rev2_mode = 1'b0;
    logic [2:0]  route_sel = 3'd0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_val, compare_val;
    logic [7:0]  irq_lines;
    logic        pend_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cc_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .count_freeze (count_freeze),
        .rev2_mode    (rev2_mode),
        .route_sel    (route_sel),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .count_val    (count_val),
        .compare_val  (compare_val),
        .irq_lines    (irq_lines),
        .pend_flag    (pend_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic sel, input logic [31:0] d,
                        input logic tk, input logic fz);
        wr_en = we; wr_sel = sel; wr_data = d; tick_en = tk; count_freeze = fz;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 count", count_val, 32'd0);
        check("R1 compare", compare_val, 32'd0);
        check("R1 irq", {24'd0, irq_lines}, 32'd0);
        check("R1 pend", {31'd0, pend_flag}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].we; wr_sel = VECS[i].sel; wr_data = VECS[i].data;
            tick_en = VECS[i].tick; count_freeze = VECS[i].frz;
            rev2_mode = VECS[i].rev2; route_sel = VECS[i].route;
            @(negedge clk);
            check($sformatf("vec%0d count", i), count_val, VECS[i].ecnt);
            check($sformatf("vec%0d irq", i), {24'd0, irq_lines}, {24'd0, VECS[i].eirq});
            check($sformatf("vec%0d pend", i), {31'd0, pend_flag}, {31'd0, VECS[i].epend});
        end
        check("R6 compare value", compare_val, 32'h10);

        // R3 wrap and match at zero, routed to line 0
        rev2_mode = 1'b1; route_sel = 3'd0;
        step(1'b1, 1'b1, 32'd0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
        check("R3 pre-wrap", count_val, 32'hFFFF_FFFF);
        check("R7 no early irq", {24'd0, irq_lines}, 32'd0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
        check("R3 wrap", count_val, 32'd0);
        check("R7 irq at wrap", {24'd0, irq_lines}, 32'h01);
        check("R8 pend at wrap", {31'd0, pend_flag}, 32'd1);

        // R9 compare write in the same cycle as a match
        step(1'b1, 1'b0, 32'h20, 1'b0, 1'b0);
        step(1'b1, 1'b1, 32'h22, 1'b0, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 32'h50, 1'b1, 1'b0);
        check("R9 clear wins count", count_val, 32'h22);
        check("R9 clear wins irq", {24'd0, irq_lines}, 32'd0);
        check("R9 clear wins pend", {31'd0, pend_flag}, 32'd0);

        // R4 freeze on the match step, then release
        step(1'b1, 1'b0, 32'h4F, 1'b0, 1'b0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 1'b1);
        check("R4 frozen count", count_val, 32'h4F);
        check("R4 frozen no match", {24'd0, irq_lines}, 32'd0);
        step(1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
        check("R7 match after release", {24'd0, irq_lines}, 32'h01);

        // R5 loading the compare value into the counter raises nothing
        step(1'b1, 1'b1, 32'h60, 1'b0, 1'b0);
        step(1'b1, 1'b0, 32'h60, 1'b0, 1'b0);
        check("R5 load equal count", count_val, 32'h60);
        check("R5 load no irq", {24'd0, irq_lines}, 32'd0);

        // R1 reset mid-run
        step(1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 mid reset count", count_val, 32'd0);
        check("R1 mid reset compare", compare_val, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule